// File: doc/BRIEF.md
# Disk controller command/result sequencer

This block is the byte-serial command engine of a legacy floppy-style disk controller. A host writes commands one byte at a time into a data port and reads result bytes back from the same port. A main status byte tells the host whether the engine is ready for a byte, which way the next byte moves, and whether a command is in progress. Each command passes through up to three phases: command (opcode and parameters), execution, and result.

The engine tracks one present cylinder. It supports absolute seek, relative seek in either direction, sense interrupt, and read ID. Read ID waits a parameterised number of clock cycles before it reports, which stands in for the time until a sector header passes under the head. One interrupt output reports that a seek or a read ID has completed. A sense interrupt clears it. For read ID, reading the last result byte clears it.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset, status_o reads 0x80, irq_o is low and the present cylinder is 0.
- R2: Status bit 7 is request-for-master, bit 6 is direction (1 = engine to host), bit 5 is non-DMA execution (always 0 here), and bit 4 is busy. The status reads 0x80 when idle in command phase, 0x90 while parameters are being collected, 0x10 during execution and 0xD0 in result phase.
- R3: Seek (opcode 0x0F) takes a head/drive byte (bit 2 = head, bits 1:0 = drive) and then a target cylinder. On the last byte the cylinder is loaded and irq_o rises. The engine returns to 0x80 with no result phase.
- R4: Relative seek takes a head/drive byte and then a step count. Opcode 0xCF adds the count to the cylinder and saturates at 255. Opcode 0x8F subtracts it and saturates at 0. On completion irq_o rises and there is no result phase.
- R5: Sense interrupt (0x08) after a completed seek returns two bytes: 0x20 OR (head << 2 | drive), then the present cylinder. irq_o drops in the cycle after the opcode is accepted.
- R6: Sense interrupt with no seek completion pending returns the single byte 0x80.
- R7: Read ID (0x0A) takes one head/drive byte. It then stays in execution (status 0x10) for exactly DELAY_CYCLES clock cycles, then enters result phase with irq_o high.
- R8: The read ID result is seven bytes: head<<2|drive, 0, 0, present cylinder, head, 1, 2. irq_o stays high until the seventh byte is read and is low afterwards.
- R9: Reading the last result byte of any command returns the status to 0x80.
- R10: Any other opcode returns the single byte 0x80, leaves irq_o unchanged and returns to command phase.
- R11: Writes outside the command and parameter phases are ignored. Reads outside result phase return 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host writes a byte to the data port |
| wr_data_i | input | 8 | Byte written by the host |
| rd_en_i | input | 1 | Host reads a byte from the data port |
| rd_data_o | output | 8 | Current result byte (0 outside result phase) |
| status_o | output | 8 | Main status byte |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two collisions matter here: a host write can arrive in the same cycle as the read ID timer expiring, and a host write can arrive in the same cycle as a result-byte read. The bench drives the opcode 0x0F on the final execution cycle, and both enables at once during result phase. The opcode is chosen because, if it were wrongly accepted, it would move the status to 0x90. Each case is judged on the result bytes that follow and on the status reading 0x80, not 0x90, once the result phase ends.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_PARAM, PH_EXEC, PH_RES} phase_e;

  localparam logic [7:0] OP_SEEK    = 8'h0F;
  localparam logic [7:0] OP_REL_IN  = 8'hCF;
  localparam logic [7:0] OP_REL_OUT = 8'h8F;
  localparam logic [7:0] OP_SENSE   = 8'h08;
  localparam logic [7:0] OP_READ_ID = 8'h0A;

  localparam logic [7:0] ST_IDLE  = 8'h80;
  localparam logic [7:0] ST_PARAM = 8'h90;
  localparam logic [7:0] ST_EXEC  = 8'h10;
  localparam logic [7:0] ST_RES   = 8'hD0;
  localparam logic [7:0] ST0_SEEK_END = 8'h20;
  localparam logic [7:0] ST0_INVALID  = 8'h80;
endpackage

// File: rtl/fdc_delay_timer.sv
module fdc_delay_timer #(
  parameter int unsigned DELAY = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CW'(DELAY - 1);
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: window counts down one per cycle
  a_r7_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !start_i) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [$clog2(DEPTH+1)-1:0] len_i,
  input  logic [DEPTH*W-1:0]   data_i,
  input  logic                 pop_i,
  output logic [W-1:0]         data_o,
  output logic                 last_o
);
  localparam int unsigned IW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] idx_q, len_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (load_i) mem_q[g] <= data_i[g*W +: W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= IW'(1);
    end else if (load_i) begin
      idx_q <= '0;
      len_q <= len_i;
    end else if (pop_i && !last_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign data_o = (idx_q < IW'(DEPTH)) ? mem_q[idx_q[IW-1:0]] : '0;
  assign last_o = (idx_q == len_q - 1'b1);

  // R8: each read advances to the next stored byte
  a_r8_pop_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !last_o && !load_i) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] status_o,
  output logic       irq_o
);
  localparam int unsigned RES_DEPTH = 7;
  localparam int unsigned LW = $clog2(RES_DEPTH + 1);

  phase_e       phase_q;
  logic [7:0]   op_q, cyl_q;
  logic [1:0]   pcnt_q;
  logic [2:0]   hd_q;
  logic         irq_q, pend_q;

  logic                     ld;
  logic [LW-1:0]            ld_len;
  logic [RES_DEPTH*8-1:0]   ld_data;
  logic                     tmr_start, tmr_done, pop, buf_last;
  logic [7:0]               buf_data;
  logic [8:0]               sum;

  assign pop       = rd_en_i && (phase_q == PH_RES);
  assign tmr_start = wr_en_i && (phase_q == PH_PARAM) && (op_q == OP_READ_ID);
  assign sum       = {1'b0, cyl_q} + {1'b0, wr_data_i};

  // result loading: byte 0 is read first
  always_comb begin
    ld      = 1'b0;
    ld_len  = LW'(1);
    ld_data = '0;
    ld_data[7:0] = ST0_INVALID;
    if (phase_q == PH_CMD && wr_en_i) begin
      unique case (wr_data_i)
        OP_SEEK, OP_REL_IN, OP_REL_OUT, OP_READ_ID: ld = 1'b0;
        OP_SENSE: begin
          ld = 1'b1;
          if (pend_q) begin
            ld_len        = LW'(2);
            ld_data[7:0]  = ST0_SEEK_END | {5'b0, hd_q};
            ld_data[15:8] = cyl_q;
          end
        end
        default: ld = 1'b1;
      endcase
    end else if (phase_q == PH_EXEC && tmr_done) begin
      ld      = 1'b1;
      ld_len  = LW'(RES_DEPTH);
      ld_data = {8'd2, 8'd1, {7'b0, hd_q[2]}, cyl_q, 8'd0, 8'd0, {5'b0, hd_q}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      op_q    <= '0;
      cyl_q   <= '0;
      pcnt_q  <= '0;
      hd_q    <= '0;
      irq_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_CMD: if (wr_en_i) begin
          op_q <= wr_data_i;
          unique case (wr_data_i)
            OP_SEEK, OP_REL_IN, OP_REL_OUT: begin
              pcnt_q <= 2'd2;
              phase_q <= PH_PARAM;
            end
            OP_READ_ID: begin
              pcnt_q <= 2'd1;
              phase_q <= PH_PARAM;
            end
            OP_SENSE: begin
              if (pend_q) irq_q <= 1'b0;
              pend_q  <= 1'b0;
              phase_q <= PH_RES;
            end
            default: phase_q <= PH_RES;
          endcase
        end
        PH_PARAM: if (wr_en_i) begin
          if (op_q == OP_READ_ID) begin
            hd_q    <= wr_data_i[2:0];
            phase_q <= PH_EXEC;
          end else if (pcnt_q == 2'd2) begin
            hd_q   <= wr_data_i[2:0];
            pcnt_q <= 2'd1;
          end else begin
            unique case (op_q)
              OP_REL_IN:  cyl_q <= sum[8] ? 8'hFF : sum[7:0];
              OP_REL_OUT: cyl_q <= (cyl_q >= wr_data_i) ? cyl_q - wr_data_i : 8'h00;
              default:    cyl_q <= wr_data_i;
            endcase
            irq_q   <= 1'b1;
            pend_q  <= 1'b1;
            pcnt_q  <= 2'd0;
            phase_q <= PH_CMD;
          end
        end
        PH_EXEC: if (tmr_done) begin
          irq_q   <= 1'b1;
          pend_q  <= 1'b0;
          phase_q <= PH_RES;
        end
        PH_RES: if (pop && buf_last) begin
          if (op_q == OP_READ_ID) irq_q <= 1'b0;
          phase_q <= PH_CMD;
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  fdc_delay_timer #(.DELAY(DELAY_CYCLES)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  fdc_result_buf #(.DEPTH(RES_DEPTH), .W(8)) rbuf_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .len_i  (ld_len),
    .data_i (ld_data),
    .pop_i  (pop),
    .data_o (buf_data),
    .last_o (buf_last)
  );

  always_comb begin
    unique case (phase_q)
      PH_PARAM: status_o = ST_PARAM;
      PH_EXEC:  status_o = ST_EXEC;
      PH_RES:   status_o = ST_RES;
      default:  status_o = ST_IDLE;
    endcase
  end

  assign rd_data_o = (phase_q == PH_RES) ? buf_data : 8'h00;
  assign irq_o     = irq_q;

  // R3/R4: seek completion raises irq and returns to command phase
  a_r3_seek_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PARAM && wr_en_i && pcnt_q == 2'd1 && op_q != OP_READ_ID)
    |=> (irq_o && status_o == ST_IDLE));
  // R5: sense interrupt drops irq
  a_r5_sense_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD && wr_en_i && wr_data_i == OP_SENSE) |=> !irq_o);
  // R8: read ID irq drops with the final byte
  a_r8_irq_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && buf_last && op_q == OP_READ_ID) |=> !irq_o);
  // R9: final read returns to idle
  a_r9_back_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && buf_last) |=> (status_o == ST_IDLE));
  // R11: execution leaves the cylinder untouched
  a_r11_exec_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC) |=> $stable(cyl_q));
endmodule

// File: tb/fdc_cmd_seq_tb_top.sv
module fdc_cmd_seq_tb_top;
  localparam int unsigned DLY = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, status;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  fdc_cmd_seq #(.DELAY_CYCLES(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .status_o(status), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    b = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic sense_chk(string req, logic [2:0] hd, logic [7:0] cyl);
    logic [7:0] b;
    wr(8'h08);
    chk("R5 irq cleared", {7'b0, irq}, 8'h00);
    chk("R2 result status", status, 8'hD0);
    rd(b); chk(req, b, 8'h20 | {5'b0, hd});
    rd(b); chk(req, b, cyl);
    chk("R9 idle", status, 8'h80);
  endtask

  task automatic read_id_chk(logic [2:0] hd, logic [7:0] cyl, bit collide);
    logic [7:0] b, exp [7];
    exp = '{{5'b0, hd}, 8'd0, 8'd0, cyl, {7'b0, hd[2]}, 8'd1, 8'd2};
    wr(8'h0A);
    chk("R2 param status", status, 8'h90);
    wr({5'b0, hd});
    for (int i = 0; i < DLY; i++) begin
      chk("R7 exec status", status, 8'h10);
      if (collide && i == DLY - 1) begin
        wr(8'h0F);
      end else @(negedge clk);
    end
    chk("R7 result status", status, 8'hD0);
    chk("R7 irq", {7'b0, irq}, 8'h01);
    for (int i = 0; i < 7; i++) begin
      if (i < 6) chk("R8 irq held", {7'b0, irq}, 8'h01);
      if (collide && i == 3) wr_en = 1'b1;
      wr_data = 8'h0F;
      rd(b);
      wr_en = 1'b0;
      chk("R8 byte", b, exp[i]);
    end
    chk("R8 irq dropped", {7'b0, irq}, 8'h00);
    chk("R9 idle", status, 8'h80);
  endtask

  task automatic seek(logic [7:0] op, logic [2:0] hd, logic [7:0] v);
    wr(op);
    chk("R2 param status", status, 8'h90);
    wr({5'b0, hd});
    wr(v);
    chk("R3 idle after seek", status, 8'h80);
    chk("R3 irq raised", {7'b0, irq}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    read_id_chk(3'd0, 8'd0, 1'b0);  // R1 cylinder 0

    // R6 nothing pending
    wr(8'h08); rd(b); chk("R6 byte", b, 8'h80);
    chk("R9 idle", status, 8'h80);

    // R10 unknown opcodes
    for (int op = 0; op < 256; op += 17) begin
      if (op == 8'h0F || op == 8'h08 || op == 8'h0A || op == 8'hCF || op == 8'h8F) continue;
      wr(8'(op));
      chk("R10 status", status, 8'hD0);
      rd(b); chk("R10 byte", b, 8'h80);
      chk("R10 irq", {7'b0, irq}, 8'h00);
      chk("R9 idle", status, 8'h80);
    end

    // R3/R5 exhaustive absolute seek
    for (int c = 0; c < 256; c++) begin
      seek(8'h0F, 3'(c), 8'(c));
      sense_chk("R5 seek sense", 3'(c), 8'(c));
    end

    // R4 relative seeks, including saturation
    for (int s = 0; s < 40; s += 3) begin
      int base = 100 + s;
      seek(8'h0F, 3'd0, 8'(base)); sense_chk("R5", 3'd0, 8'(base));
      seek(8'hCF, 3'd5, 8'(s));    sense_chk("R4 inward", 3'd5, 8'(base + s));
      seek(8'h8F, 3'd2, 8'(2*s));  sense_chk("R4 outward", 3'd2, 8'(base - s));
    end
    seek(8'h0F, 3'd0, 8'd250); sense_chk("R5", 3'd0, 8'd250);
    seek(8'hCF, 3'd0, 8'd10);  sense_chk("R4 sat high", 3'd0, 8'd255);
    seek(8'h0F, 3'd0, 8'd3);   sense_chk("R5", 3'd0, 8'd3);
    seek(8'h8F, 3'd0, 8'd5);   sense_chk("R4 sat low", 3'd0, 8'd0);

    // R7/R8 read ID over all head/drive values
    for (int h = 0; h < 8; h++) begin
      seek(8'h0F, 3'(h), 8'(8 + h)); sense_chk("R5", 3'(h), 8'(8 + h));
      read_id_chk(3'(h), 8'(8 + h), h[0]);  // odd: R11 collisions
    end

    // R11 read outside result phase
    seek(8'h0F, 3'd1, 8'd77);
    rd(b); chk("R11 read in cmd", b, 8'h00);
    chk("R11 status", status, 8'h80);
    sense_chk("R11 state kept", 3'd1, 8'd77);

    // R1 reset mid-command
    wr(8'h0A); wr(8'h00);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 status after reset", status, 8'h80);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    read_id_chk(3'd4, 8'd0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule